// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Detection

A 32-pin general-purpose I/O port reached over a small memory-mapped register bus. Software drives pads through an output data register gated by an output-enable register. It reads pad levels through a two-stage synchronizer. Each pin can also raise an interrupt. Every writable register can be written directly. Each also has a bit-set alias and a bit-clear alias, so single bits can change without a read-modify-write.

For interrupts, each pin has four configuration bits: a routing bit that lets the pin reach the detector, an enable, a level-versus-edge bit and a polarity bit. Detected events latch into a sticky status register. Status bits are removed only through the clear alias of that register. One interrupt line covers the whole port. It is high whenever an enabled pin has a pending status bit.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `pad_out` and `pad_oe` are 0 and `irq_out` is 0.
- R2: Address bits [6:4] select the register: 0 output data, 1 output enable, 2 input data, 3 interrupt routing, 4 interrupt enable, 5 level select, 6 polarity, 7 status. Bits [3:2] select the access: 0 plain write, 1 set alias, 2 clear alias, 3 writes ignored. Reads at any of the four offsets return the register. `bus_rdata` follows `bus_addr` within the same cycle.
- R3: A plain write loads the register on the next clock edge. A set-alias write ORs the data into it, and a clear-alias write removes the bits that are 1 in the data. All other bits keep their value.
- R4: `pad_oe` equals the output-enable register, and `pad_out` equals output data AND output enable.
- R5: The input data register shows `pad_in` after two clock edges. Writes at its address have no effect.
- R6: The trigger of pin i is set by {polarity[i], level[i]}: 00 falling edge, 01 low level, 10 rising edge, 11 high level.
- R7: An edge on `pad_in` that is present at clock edge k sets the status bit at edge k+2. `irq_out` (when enabled) is therefore first high after edge k+2.
- R8: In level mode the status bit is set again on every cycle the active level is present. A clear-alias write during the active level leaves the bit set.
- R9: A pin whose routing bit is 0 never sets its status bit, whatever its pad does.
- R10: Status bits are sticky. Plain and set-alias writes to the status address change nothing, and only clear-alias writes remove bits.
- R11: `irq_out` is the OR of (status AND enable), with no added delay. A pin whose enable is 0 still latches status, and setting its enable later raises `irq_out` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq_out | output | 1 | Aggregated port interrupt |

## Verification
The hardest case to reach from the ports is a clear-alias write landing in the same cycle as a fresh detection on the same pin. That pin has to be in level mode with its level still present, or have an edge two cycles behind the write. The directed part holds a low level on a routed pin while clearing it. The random part toggles sparse pad bits while writing random data to all eight addresses and all four access offsets, so that collisions of a clear with a hit, of a configuration change with an edge in flight, and of routing off with a pending edge happen many times. Outputs and read data are compared every cycle with a bench model built from the requirements.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and access encoding for the GPIO port.
// Assumes one 16-byte block per register and word-aligned aliases.
package gpio_irq_pkg;
    localparam int SLOT_LSB    = 4;
    localparam int N_SLOTS     = 8;
    localparam int SLOT_W      = $clog2(N_SLOTS);
    localparam int GPIO_ADDR_W = SLOT_LSB + SLOT_W;

    // register slots; the order is the address map
    localparam int SL_DOUT = 0;
    localparam int SL_OE   = 1;
    localparam int SL_DIN  = 2;
    localparam int SL_SEL  = 3;
    localparam int SL_EN   = 4;
    localparam int SL_LEV  = 5;
    localparam int SL_POL  = 6;
    localparam int SL_STAT = 7;

    typedef enum logic [1:0] {
        ACC_RW   = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;
endpackage

// File: rtl/gpio_bus_decode.sv
`timescale 1ns/1ps
// Module: gpio_bus_decode
// Splits a byte address into a register slot and an access kind.
// Produces one-hot write strobes per slot. Assumes bits [1:0] are zero.
module gpio_bus_decode
    import gpio_irq_pkg::*;
(
    input  logic [GPIO_ADDR_W-1:0] addr,
    input  logic                   wr_en,
    output logic [N_SLOTS-1:0]     do_rw,
    output logic [N_SLOTS-1:0]     do_set,
    output logic [N_SLOTS-1:0]     do_clr,
    output logic [SLOT_W-1:0]      slot
);
    acc_e       acc;
    logic [1:0] unused_lsb;

    // field extraction
    always_comb begin
        slot       = addr[SLOT_LSB +: SLOT_W];
        acc        = acc_e'(addr[3:2]);
        unused_lsb = addr[1:0];
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_strobe
        logic hit_slot;
        // per-slot strobe generation
        always_comb begin
            hit_slot  = wr_en && (slot == SLOT_W'(s));
            do_rw[s]  = hit_slot && (acc == ACC_RW);
            do_set[s] = hit_slot && (acc == ACC_SET);
            do_clr[s] = hit_slot && (acc == ACC_CLR);
        end
    end
endmodule

// File: rtl/gpio_cfg_reg.sv
`timescale 1ns/1ps
// Module: gpio_cfg_reg
// One register with plain, set and clear write paths.
// Assumes at most one strobe is active per cycle.
module gpio_cfg_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         do_rw,
    input  logic         do_set,
    input  logic         do_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // register update with the alias semantics
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (do_rw)  q <= wdata;
        else if (do_set) q <= q | wdata;
        else if (do_clr) q <= q & ~wdata;
    end

    // R3
    set_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_set |=> (($past(q) & ~q) == '0));
    // R3
    clr_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> ((q & ~$past(q)) == '0));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_rw || do_set || do_clr) |=> $stable(q));
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Module: gpio_in_sync
// Two-flop synchronizer for asynchronous pads, plus a one-cycle-old copy
// of the synchronized value for edge detection.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    // synchronizer chain and history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
// Module: gpio_irq_detect
// Per-pin trigger evaluation, sticky status and the port interrupt.
// Assumes sync/prev come from gpio_in_sync. A hit in the same cycle as a
// clear wins, so a level trigger cannot be cleared while active.
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] prev_in,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] en,
    input  logic [W-1:0] lev,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status_q,
    output logic         irq_o
);
    logic [W-1:0] trig;
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall;
        // trigger selection from {polarity, level}
        always_comb begin
            rise = sync_in[i] & ~prev_in[i];
            fall = ~sync_in[i] & prev_in[i];
            case ({pol[i], lev[i]})
                2'b00:   trig[i] = fall;
                2'b01:   trig[i] = ~sync_in[i];
                2'b10:   trig[i] = rise;
                default: trig[i] = sync_in[i];
            endcase
        end
    end

    // routing gate and port interrupt
    always_comb begin
        hit   = trig & sel;
        irq_o = |(status_q & en);
    end

    // sticky status: set by hits, cleared by the clear alias
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | hit;
    end

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status_q) & ~$past(clr_mask)) & ~status_q) == '0));
    // R9
    route_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((status_q & ~$past(status_q)) & ~$past(sel)) == '0));
    // R7
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((status_q & ~$past(status_q)) & ~$past(lev)
          & ~($past(sync_in) ^ $past(prev_in))) == '0));
    // R11
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_q != '0));
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
// Module: gpio_irq_port (top)
// GPIO port with aliased registers, input synchronizer and pin interrupts.
// Assumes one bus access per cycle and reads that are free of side effects.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0]      bus_wdata,
    output logic [N_PINS-1:0]      bus_rdata,
    input  logic [N_PINS-1:0]      pad_in,
    output logic [N_PINS-1:0]      pad_out,
    output logic [N_PINS-1:0]      pad_oe,
    output logic                   irq_out
);
    logic [N_SLOTS-1:0] do_rw, do_set, do_clr;
    logic [SLOT_W-1:0]  slot;
    logic [N_PINS-1:0]  reg_q [N_SLOTS];
    logic [N_PINS-1:0]  sync_q, prev_q, stat_q, stat_clr;
    logic               unused_strobes;

    gpio_bus_decode u_dec (
        .addr   (bus_addr),
        .wr_en  (bus_wr),
        .do_rw  (do_rw),
        .do_set (do_set),
        .do_clr (do_clr),
        .slot   (slot)
    );

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_reg
        if (s == SL_DIN) begin : g_din
            assign reg_q[s] = sync_q;
        end else if (s == SL_STAT) begin : g_stat
            assign reg_q[s] = stat_q;
        end else begin : g_cfg
            gpio_cfg_reg #(.W(N_PINS)) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .do_rw  (do_rw[s]),
                .do_set (do_set[s]),
                .do_clr (do_clr[s]),
                .wdata  (bus_wdata),
                .q      (reg_q[s])
            );
        end
    end

    gpio_in_sync #(.W(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    // status is cleared only through its clear alias
    always_comb begin
        stat_clr       = do_clr[SL_STAT] ? bus_wdata : '0;
        unused_strobes = ^{do_rw[SL_DIN], do_set[SL_DIN], do_clr[SL_DIN],
                           do_rw[SL_STAT], do_set[SL_STAT]};
    end

    gpio_irq_detect #(.W(N_PINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_q),
        .prev_in  (prev_q),
        .sel      (reg_q[SL_SEL]),
        .en       (reg_q[SL_EN]),
        .lev      (reg_q[SL_LEV]),
        .pol      (reg_q[SL_POL]),
        .clr_mask (stat_clr),
        .status_q (stat_q),
        .irq_o    (irq_out)
    );

    // read mux and pad drive
    always_comb begin
        bus_rdata = reg_q[slot];
        pad_oe    = reg_q[SL_OE];
        pad_out   = reg_q[SL_DOUT] & reg_q[SL_OE];
    end

    // R4
    pad_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));
endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
    localparam int CLK_P = 10;
    localparam int NP    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          b_wr = 1'b0;
    logic [6:0]    b_addr = '0;
    logic [NP-1:0] b_wdata = '0;
    logic [NP-1:0] rdata, pad_out, pad_oe;
    logic [NP-1:0] pad_in = '0;
    logic          irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    logic [NP-1:0] m_reg [8];
    logic [NP-1:0] m_s1, m_s2, m_pv;

    always #(CLK_P/2) clk = ~clk;

    gpio_irq_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq)
    );

    function automatic logic [NP-1:0] apply(input logic [1:0] acc,
        input logic [NP-1:0] q, input logic [NP-1:0] d);
        case (acc)
            2'd0: return d;
            2'd1: return q | d;
            2'd2: return q & ~d;
            default: return q;
        endcase
    endfunction

    function automatic logic [NP-1:0] m_hit();
        logic [NP-1:0] t;
        for (int i = 0; i < NP; i++) begin
            case ({m_reg[6][i], m_reg[5][i]})
                2'b00: t[i] = m_pv[i] & ~m_s2[i];
                2'b01: t[i] = ~m_s2[i];
                2'b10: t[i] = m_s2[i] & ~m_pv[i];
                default: t[i] = m_s2[i];
            endcase
        end
        return t & m_reg[3];
    endfunction

    function automatic logic [NP-1:0] m_read(input logic [6:0] a);
        return (a[6:4] == 3'd2) ? m_s2 : m_reg[a[6:4]];
    endfunction

    // model update from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 8; s++) m_reg[s] <= '0;
            m_s1 <= '0; m_s2 <= '0; m_pv <= '0;
        end else begin
            logic [NP-1:0] h;
            h = m_hit();
            m_reg[7] <= (b_wr && b_addr[6:4] == 3'd7 && b_addr[3:2] == 2'd2)
                        ? ((m_reg[7] & ~b_wdata) | h) : (m_reg[7] | h);
            for (int s = 0; s < 7; s++)
                if (s != 2 && b_wr && b_addr[6:4] == 3'(s))
                    m_reg[s] <= apply(b_addr[3:2], m_reg[s], b_wdata);
            m_s1 <= pad_in; m_s2 <= m_s1; m_pv <= m_s2;
        end
    end

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        b_addr = a; b_wdata = d; b_wr = 1'b1;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [NP-1:0] v);
        b_addr = a; #1; v = rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [NP-1:0] v;
        void'($urandom(32'h1A2B3C4D));
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        for (int s = 0; s < 8; s++) begin
            rd(7'(s << 4), v); chk("R1 reg", v, '0);
        end
        chk("R1 pad_out", pad_out, '0);
        chk("R1 irq", {31'd0, irq}, '0);

        // R3 R4 aliases and pad gating
        wr(7'h00, 32'hF0F0_F0F0);
        wr(7'h14, 32'h00FF_00FF);
        chk("R4 pad_out", pad_out, 32'h00F0_00F0);
        chk("R4 pad_oe", pad_oe, 32'h00FF_00FF);
        wr(7'h04, 32'h0000_000F);
        wr(7'h08, 32'hF000_0000);
        rd(7'h04, v); chk("R3 set/clr via set alias read", v, 32'h00F0_F0FF);
        rd(7'h08, v); chk("R2 clr alias read", v, 32'h00F0_F0FF);
        wr(7'h0C, 32'h0);
        rd(7'h00, v); chk("R2 offset 0xC ignored", v, 32'h00F0_F0FF);
        chk("R4 pad_out after alias", pad_out, 32'h00F0_00FF);

        // R5 synchronizer latency and read-only input
        @(negedge clk); pad_in[0] = 1'b1;
        rd(7'h20, v); chk("R5 din edge0", v, 32'h0);
        step(1); rd(7'h20, v); chk("R5 din edge1", v, 32'h0);
        step(1); rd(7'h20, v); chk("R5 din edge2", v, 32'h1);
        wr(7'h20, 32'h0);
        rd(7'h20, v); chk("R5 din write ignored", v, 32'h1);

        // R7 rising edge timing on pin 4
        wr(7'h34, 32'h10); wr(7'h44, 32'h10); wr(7'h64, 32'h10);
        pad_in[4] = 1'b1;
        step(1); chk("R7 irq after 1 edge", {31'd0, irq}, 0);
        step(1); chk("R7 irq after 2 edges", {31'd0, irq}, 0);
        step(1); chk("R7 irq after 3 edges", {31'd0, irq}, 1);
        // R10 sticky status
        wr(7'h70, 32'h0);
        rd(7'h70, v); chk("R10 plain write ignored", v, 32'h10);
        wr(7'h74, 32'hFFFF_FFFF);
        rd(7'h70, v); chk("R10 set write ignored", v, 32'h10);
        wr(7'h78, 32'h10);
        rd(7'h70, v); chk("R10 clear alias", v, 32'h0);
        chk("R11 irq drops", {31'd0, irq}, 0);

        // R8 low-level trigger on pin 5 held across a clear
        wr(7'h34, 32'h20); wr(7'h54, 32'h20); wr(7'h44, 32'h20);
        rd(7'h70, v); chk("R6 R8 low level sets", v, 32'h20);
        wr(7'h78, 32'h20);
        rd(7'h70, v); chk("R8 clear while active", v, 32'h20);
        pad_in[5] = 1'b1;
        step(3);
        wr(7'h78, 32'h20);
        rd(7'h70, v); chk("R8 clear after release", v, 32'h0);
        chk("R8 irq", {31'd0, irq}, 0);

        // R9 unrouted pin 6
        wr(7'h44, 32'h40); wr(7'h64, 32'h40);
        pad_in[6] = 1'b1; step(3);
        pad_in[6] = 1'b0; step(3);
        rd(7'h70, v); chk("R9 unrouted status", v, 32'h0);
        chk("R9 irq", {31'd0, irq}, 0);

        // R11 disabled pin 7 still latches, falling edge (R6)
        wr(7'h34, 32'h80);
        pad_in[7] = 1'b1; step(3);
        rd(7'h70, v); chk("R6 rise ignored in fall mode", v, 32'h0);
        pad_in[7] = 1'b0; step(3);
        rd(7'h70, v); chk("R11 masked status set", v, 32'h80);
        chk("R11 irq masked", {31'd0, irq}, 0);
        wr(7'h44, 32'h80);
        chk("R11 irq on enable", {31'd0, irq}, 1);
        wr(7'h78, 32'hFFFF_FFFF);

        // random phase against the model
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            chk("R4 rand pad_out", pad_out, m_reg[0] & m_reg[1]);
            chk("R4 rand pad_oe", pad_oe, m_reg[1]);
            chk("R11 rand irq", {31'd0, irq}, {31'd0, |(m_reg[7] & m_reg[4])});
            b_wr = ($urandom % 4) == 0;
            b_addr = {3'($urandom), 2'($urandom), 2'b00};
            b_wdata = $urandom & $urandom;
            #1;
            chk("R2 R6 rand read", rdata, m_read(b_addr));
            pad_in = pad_in ^ ($urandom & $urandom & $urandom);
        end
        @(negedge clk); b_wr = 1'b0;
        done = 1;
        summary();
    end
endmodule